// File: doc/BRIEF.md
# IPv4 Fast-Path Header Check and Rewrite

This block sits in a forwarding engine's fast path. Each transfer on its input carries a complete 20-byte IPv4 header as five parallel 32-bit words, together with the datagram length that the link layer measured. The block decides whether the header can be forwarded without software help. For a forwardable header it lowers the TTL by one and adjusts the header checksum incrementally. Every result leaves with a disposition code that tells the surrounding logic what to do with the datagram.

The block never recomputes or verifies the incoming checksum. It only applies the change that the TTL decrement causes, so a header that arrived corrupted still carries a wrong checksum when it leaves. Datagrams addressed to the router itself, datagrams that are about to expire, multicast datagrams and unusual headers pass through unchanged and are tagged for the matching handler. A small table of up to four router addresses, written through a configuration port, identifies local traffic.

The control is a two-state machine. EMPTY means no result is held. FULL means a result is waiting on the output. The transition EMPTY→FULL takes place when a header is accepted. FULL→EMPTY takes place when the result is taken and no new header arrives. FULL→FULL takes place when a result is taken and a new header is accepted in the same cycle. A result appears one cycle after its header is accepted.

Top module: `ipv4fp_rewrite`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and the address table holds no enabled entry, so no destination is treated as local.
- R2: A header whose version field (word 0 bits 31:28) is not 4 gets disposition SLOW (code 2) and leaves unchanged.
- R3: An IHL field (word 0 bits 27:24) greater than 5 gives SLOW (code 2). An IHL less than 5 gives DROP (code 1). In both cases the header is unchanged.
- R4: When the total-length field (word 0 bits 15:0) differs from in_llen, the disposition is DROP (code 1) and the header is unchanged.
- R5: When the destination (word 4) equals an enabled table entry, the disposition is LOCAL (code 3) and the TTL and checksum are unchanged. An entry written with cfg_en=0 never matches.
- R6: A destination whose top four bits are 1110 gets MCAST (code 5) and leaves unchanged.
- R7: An incoming TTL (word 2 bits 31:24) of 0 or 1 gives EXPIRED (code 4) and leaves unchanged.
- R8: Any other header gets FWD (code 0). Its TTL is lowered by one, its checksum (word 2 bits 15:0) gets 0x0100 added with end-around carry, and every other bit stays as it was.
- R9: The incoming checksum is never verified. Any checksum value, including 0xFF00 and 0xFFFF, is updated by the same incremental rule.
- R10: The checks are applied in a fixed order: version, then IHL, then length, then local address, then multicast, then TTL. The first check that fails decides the disposition.
- R11: in_ready is 0 exactly when out_valid is 1 and out_ready is 0. A held result stays stable until it is taken. A result appears one cycle after its header is accepted, and one header per cycle is accepted while out_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the address table |
| cfg_idx | input | IDX_W | Table entry to write |
| cfg_en | input | 1 | Enable bit stored with the entry |
| cfg_addr | input | 32 | Router address stored in the entry |
| in_valid | input | 1 | Header present on the input |
| in_ready | output | 1 | Block can accept a header this cycle |
| in_hdr | input | 160 | Header; word k occupies bits 159-32k down to 128-32k |
| in_llen | input | 16 | Datagram length reported by the link layer |
| out_valid | output | 1 | Result present on the output |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_hdr | output | 160 | Header after any rewrite, same layout as in_hdr |
| out_disp | output | 3 | Disposition: 0 FWD, 1 DROP, 2 SLOW, 3 LOCAL, 4 EXPIRED, 5 MCAST |

## Verification
Two things can happen in the same cycle: a held result leaves, and a new header is accepted into the same register (the FULL→FULL transition). The bench provokes this in two ways. It stalls the output with a header waiting, then raises out_ready. It also streams the vector table back to back. It then judges that each result matches its own header and that no result is lost or repeated. Several headers are also built to fail more than one check at once, so the fixed order in which the checks apply is tested directly.

// File: rtl/ipv4fp_pkg.sv
package ipv4fp_pkg;
    localparam int HDR_WORDS = 5;
    localparam int WORD_W    = 32;
    localparam int HDR_W     = HDR_WORDS * WORD_W;
    localparam int LEN_W     = 16;

    // bit positions inside the flat header (word 0 at the top)
    localparam int VER_LSB  = HDR_W - 4;
    localparam int IHL_LSB  = HDR_W - 8;
    localparam int TLEN_LSB = HDR_W - WORD_W;
    localparam int TTL_LSB  = HDR_W - 2 * WORD_W - 8;
    localparam int CKS_LSB  = HDR_W - 3 * WORD_W;
    localparam int DST_LSB  = 0;

    typedef enum logic [2:0] {
        DISP_FWD     = 3'd0,
        DISP_DROP    = 3'd1,
        DISP_SLOW    = 3'd2,
        DISP_LOCAL   = 3'd3,
        DISP_EXPIRED = 3'd4,
        DISP_MCAST   = 3'd5
    } disp_e;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/ipv4fp_addr_match.sv
module ipv4fp_addr_match #(
    parameter int N_ADDR = 4,
    parameter int IDX_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_en,
    input  logic [31:0]      cfg_addr,
    input  logic [31:0]      dst,
    output logic             hit
);
    logic [N_ADDR-1:0] slot_hit;

    for (genvar g = 0; g < N_ADDR; g++) begin : g_slot
        logic [31:0] addr_q;
        logic        en_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q <= '0;
                en_q   <= 1'b0;
            end else if (cfg_we && (cfg_idx == IDX_W'(g))) begin
                addr_q <= cfg_addr;
                en_q   <= cfg_en;
            end
        end
        assign slot_hit[g] = en_q && (addr_q == dst);
    end

    assign hit = |slot_hit;
endmodule

// File: rtl/ipv4fp_classify.sv
module ipv4fp_classify
    import ipv4fp_pkg::*;
(
    input  logic [HDR_W-1:0] hdr,
    input  logic [LEN_W-1:0] llen,
    input  logic             local_hit,
    output disp_e            disp
);
    logic [3:0]       ver, ihl;
    logic [LEN_W-1:0] tlen;
    logic [7:0]       ttl;
    logic [31:0]      dst;

    assign ver  = hdr[VER_LSB +: 4];
    assign ihl  = hdr[IHL_LSB +: 4];
    assign tlen = hdr[TLEN_LSB +: LEN_W];
    assign ttl  = hdr[TTL_LSB +: 8];
    assign dst  = hdr[DST_LSB +: 32];

    // first failing check wins
    always_comb begin
        if (ver != 4'd4)             disp = DISP_SLOW;
        else if (ihl > 4'd5)         disp = DISP_SLOW;
        else if (ihl < 4'd5)         disp = DISP_DROP;
        else if (tlen != llen)       disp = DISP_DROP;
        else if (local_hit)          disp = DISP_LOCAL;
        else if (dst[31:28] == 4'hE) disp = DISP_MCAST;
        else if (ttl <= 8'd1)        disp = DISP_EXPIRED;
        else                         disp = DISP_FWD;
    end
endmodule

// File: rtl/ipv4fp_cksum_upd.sv
module ipv4fp_cksum_upd (
    input  logic [7:0]  ttl_in,
    input  logic [15:0] cks_in,
    output logic [7:0]  ttl_out,
    output logic [15:0] cks_out
);
    logic [16:0] sum;

    // TTL sits in the high byte: lowering it by one raises the sum by 0x0100
    assign ttl_out = ttl_in - 8'd1;
    assign sum     = {1'b0, cks_in} + 17'h00100;
    assign cks_out = sum[15:0] + {15'd0, sum[16]};
endmodule

// File: rtl/ipv4fp_rewrite.sv
module ipv4fp_rewrite
    import ipv4fp_pkg::*;
#(
    parameter int N_ADDR = 4,
    localparam int IDX_W = (N_ADDR > 1) ? $clog2(N_ADDR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_en,
    input  logic [31:0]      cfg_addr,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [159:0]     in_hdr,
    input  logic [15:0]      in_llen,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [159:0]     out_hdr,
    output logic [2:0]       out_disp
);
    slot_state_e state_q, state_d;
    logic        accept, local_hit;
    disp_e       disp_c;
    logic [7:0]  ttl_new;
    logic [15:0] cks_new;
    logic [HDR_W-1:0] hdr_c, hdr_q;
    disp_e       disp_q;

    ipv4fp_addr_match #(.N_ADDR(N_ADDR), .IDX_W(IDX_W)) match_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_en(cfg_en), .cfg_addr(cfg_addr),
        .dst(in_hdr[DST_LSB +: 32]), .hit(local_hit)
    );

    ipv4fp_classify class_i (
        .hdr(in_hdr), .llen(in_llen), .local_hit(local_hit), .disp(disp_c)
    );

    ipv4fp_cksum_upd upd_i (
        .ttl_in(in_hdr[TTL_LSB +: 8]), .cks_in(in_hdr[CKS_LSB +: 16]),
        .ttl_out(ttl_new), .cks_out(cks_new)
    );

    always_comb begin
        hdr_c = in_hdr;
        if (disp_c == DISP_FWD) begin
            hdr_c[TTL_LSB +: 8]  = ttl_new;
            hdr_c[CKS_LSB +: 16] = cks_new;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !accept) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // handshake outputs
    always_comb begin
        unique case (state_q)
            ST_EMPTY: begin out_valid = 1'b0; in_ready = 1'b1;      end
            ST_FULL:  begin out_valid = 1'b1; in_ready = out_ready; end
            default:  begin out_valid = 1'b0; in_ready = 1'b0;      end
        endcase
    end

    assign accept = in_valid && in_ready;

    // result slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q  <= '0;
            disp_q <= DISP_FWD;
        end else if (accept) begin
            hdr_q  <= hdr_c;
            disp_q <= disp_c;
        end
    end

    assign out_hdr  = hdr_q;
    assign out_disp = disp_q;
endmodule

// File: rtl/ipv4fp_rewrite_chk.sv
module ipv4fp_rewrite_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic [159:0] in_hdr,
    input logic         out_valid,
    input logic         out_ready,
    input logic [159:0] out_hdr,
    input logic [2:0]   out_disp
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R11
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R11
    held_result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_hdr) && $stable(out_disp)));

    // R11
    one_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R2
    untouched_unless_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_disp == 3'd0 || out_hdr == $past(in_hdr)));

    // R8
    fwd_ttl_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=>
        (out_disp != 3'd0 || out_hdr[95:88] == 8'($past(in_hdr[95:88]) - 8'd1)));

    // R6
    mcast_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_disp == 3'd5) |-> (out_hdr[31:28] == 4'hE));
endmodule

bind ipv4fp_rewrite ipv4fp_rewrite_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .out_valid(out_valid), .out_ready(out_ready),
    .out_hdr(out_hdr), .out_disp(out_disp)
);

// File: tb/ipv4fp_rewrite_tb_top.sv
`timescale 1ns/1ps
module ipv4fp_rewrite_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0, cfg_en = 1'b0;
    logic [1:0]   cfg_idx = '0;
    logic [31:0]  cfg_addr = '0;
    logic         in_valid = 1'b0, out_ready = 1'b1;
    logic [159:0] in_hdr = '0;
    logic [15:0]  in_llen = '0;
    logic         in_ready, out_valid;
    logic [159:0] out_hdr;
    logic [2:0]   out_disp;
    int errors = 0, checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ipv4fp_rewrite dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_en(cfg_en), .cfg_addr(cfg_addr), .in_valid(in_valid),
        .in_ready(in_ready), .in_hdr(in_hdr), .in_llen(in_llen),
        .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr),
        .out_disp(out_disp)
    );

    localparam int NV = 16;
    localparam logic [3:0]  V_VER [NV] = '{4,4,4,6,4,4,4,4,4,4,4,4,6,4,4,4};
    localparam logic [3:0]  V_IHL [NV] = '{5,5,5,5,6,4,5,5,5,5,5,5,6,5,5,5};
    localparam logic [15:0] V_LLEN[NV] = '{100,60,60,60,60,60,61,60,60,60,60,60,61,61,60,60};
    localparam logic [7:0]  V_TTL [NV] = '{64,1,0,64,64,64,64,64,64,64,2,9,64,1,0,1};
    localparam logic [15:0] V_CKS [NV] = '{16'h1234,16'hABCD,16'hABCD,16'h1111,16'h2222,16'h3333,
        16'h4444,16'h5555,16'h6666,16'h7777,16'hFF00,16'hFFFF,16'h0000,16'h1010,16'h2020,16'h3030};
    localparam logic [31:0] V_DST [NV] = '{32'h08080808,32'h08080808,32'h08080808,32'h08080808,
        32'h08080808,32'h08080808,32'h08080808,32'h0A000001,32'hE0000005,32'h0B000001,
        32'h08080808,32'h08080808,32'h0A000001,32'h0A000001,32'hC0A80101,32'hEF000001};
    localparam logic [2:0]  V_EXP [NV] = '{0,4,4,2,2,1,1,3,5,0,0,0,2,1,3,5};
    localparam logic [15:0] V_ECK [NV] = '{16'h1334,0,0,0,0,0,0,0,0,16'h7877,16'h0001,16'h0100,0,0,0,0};

    function automatic logic [159:0] mk(input logic [3:0] ver, input logic [3:0] ihl,
        input logic [15:0] tlen, input logic [7:0] ttl, input logic [15:0] cks, input logic [31:0] dst);
        return {ver, ihl, 8'h00, tlen, 32'h1234_4000, ttl, 8'd17, cks, 32'hC0000201, dst};
    endfunction

    task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] idx, input logic en, input logic [31:0] a);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_en = en; cfg_addr = a;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [159:0] h, e, h2;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset handshake", {158'd0, out_valid, in_ready}, 160'd1);
        rst_n = 1'b1;
        cfg(2'd0, 1'b1, 32'h0A000001);
        cfg(2'd1, 1'b1, 32'hC0A80101);
        cfg(2'd2, 1'b0, 32'h0B000001);

        // vector table streamed back to back (R2..R10, R11 throughput)
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            h = mk(V_VER[i], V_IHL[i], 16'd60 + ((i == 0) ? 16'd40 : 16'd0), V_TTL[i], V_CKS[i], V_DST[i]);
            in_valid = 1'b1; in_hdr = h; in_llen = V_LLEN[i];
            @(negedge clk);
            e = h;
            if (V_EXP[i] == 3'd0) begin
                e[95:88] = V_TTL[i] - 8'd1;
                e[79:64] = V_ECK[i];
            end
            check(out_valid == 1'b1, $sformatf("R11 vec%0d valid", i), {159'd0, out_valid}, 160'd1);
            check(out_disp == V_EXP[i], $sformatf("R10 R2 R3 R4 R5 R6 R7 R8 vec%0d disp", i),
                  {157'd0, out_disp}, {157'd0, V_EXP[i]});
            check(out_hdr == e, $sformatf("R8 R9 vec%0d header", i), out_hdr, e);
        end
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R11 drains", {159'd0, out_valid}, 160'd0);

        // stall, then release with a new header waiting (R11)
        h  = mk(4, 5, 60, 30, 16'h0101, 32'h01020304);
        h2 = mk(4, 5, 60, 1, 16'h0202, 32'h01020305);
        out_ready = 1'b0; in_valid = 1'b1; in_hdr = h; in_llen = 16'd60;
        @(negedge clk);
        in_hdr = h2;
        e = h; e[95:88] = 8'd29; e[79:64] = 16'h0201;
        for (int k = 0; k < 3; k++) begin
            check(in_ready == 1'b0, "R11 stall blocks input", {159'd0, in_ready}, 160'd0);
            check(out_hdr == e && out_disp == 3'd0, "R11 held result", out_hdr, e);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_hdr == h2 && out_disp == 3'd4, "R11 swap in same cycle", out_hdr, h2);
        @(negedge clk);

        // reset clears the address table (R1)
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        h = mk(4, 5, 60, 64, 16'h0000, 32'h0A000001);
        in_valid = 1'b1; in_hdr = h; in_llen = 16'd60;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_disp == 3'd0, "R1 table empty after reset", {157'd0, out_disp}, 160'd0);
        @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule